// File: doc/BRIEF.md
# Modem Handshake Register with Diagnostic Loopback

This block holds the byte-wide modem control register of a serial port. A host writes and reads it over a single-register bus made of a write strobe, a read strobe and byte-wide data. The low four register bits drive the four modem handshake outputs: data-terminal-ready, request-to-send and two general-purpose outputs. The receiver's serial input and the four modem status lines pass through the block on their way to the rest of the port. The serial shifters, the baud generator and the interrupt logic sit outside it.

Bit 4 of the register enables a diagnostic loopback. The block decodes a mode from that bit, with two modes: MODE_NORMAL and MODE_LOOP. A host write with bit 4 set moves the block from MODE_NORMAL to MODE_LOOP. A write with bit 4 clear moves it back. Reset places it in MODE_NORMAL. In MODE_LOOP the external serial output sits at idle-high and the external serial input is ignored. The transmitter's serial stream goes straight to the receiver. The external modem status inputs are ignored, and each control bit takes the place of one status line. The external control pins are held inactive while the register keeps its values for internal use. The mode is decoded combinationally from the register bit. A mode change therefore takes effect as soon as the register updates.

Top module: `modem_ctl_loop`

## Requirements
- R1: After reset the register is zero: a read returns 0x00, all four control outputs are 0, and the block is in MODE_NORMAL, with ser_out_ext equal to tx_ser.
- R2: A clock edge with wr_en high loads wdata[4:0] into the register. In MODE_NORMAL, bit 0 then drives dtr_out, bit 1 drives rts_out, bit 2 drives out1_out and bit 3 drives out2_out, from that edge on.
- R3: While rd_en is high, rdata shows the current register contents in bits 4:0, in the same cycle. While rd_en is low, rdata is 0x00.
- R4: Register bits 7:5 always read as 0, and writing ones into them has no effect on any output.
- R5: In MODE_NORMAL, ser_out_ext follows tx_ser, rx_ser follows ser_in_ext, and dsr_eff, cts_eff, ri_eff and dcd_eff follow dsr_in, cts_in, ri_in and dcd_in.
- R6: In MODE_LOOP (bit 4 = 1), ser_out_ext is held at 1 whatever tx_ser does.
- R7: In MODE_LOOP, rx_ser follows tx_ser, and ser_in_ext has no effect on rx_ser.
- R8: In MODE_LOOP, dsr_eff equals bit 0, cts_eff equals bit 1, ri_eff equals bit 2 and dcd_eff equals bit 3. The external status inputs have no effect on these lines.
- R9: In MODE_LOOP, dtr_out, rts_out, out1_out and out2_out are all 0, while a read still returns the stored bits 3:0.
- R10: Entering or leaving MODE_LOOP takes effect at the clock edge that writes bit 4, with no extra cycle of delay.
- R11: Cycles with wr_en low leave the register unchanged, whatever wdata carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| ser_in_ext | input | 1 | External serial input |
| tx_ser | input | 1 | Transmitter's internal serial output |
| ser_out_ext | output | 1 | External serial output |
| rx_ser | output | 1 | Serial stream to the receiver |
| dsr_in | input | 1 | External data-set-ready |
| cts_in | input | 1 | External clear-to-send |
| ri_in | input | 1 | External ring indicator |
| dcd_in | input | 1 | External carrier detect |
| dtr_out | output | 1 | Data-terminal-ready pin |
| rts_out | output | 1 | Request-to-send pin |
| out1_out | output | 1 | General output 1 pin |
| out2_out | output | 1 | General output 2 pin |
| dsr_eff | output | 1 | Data-set-ready seen by status logic |
| cts_eff | output | 1 | Clear-to-send seen by status logic |
| ri_eff | output | 1 | Ring indicator seen by status logic |
| dcd_eff | output | 1 | Carrier detect seen by status logic |

## Verification
A write takes effect at the rising edge where wr_en is high. Every output that depends on the register, including the loopback routing, settles just after that edge. The bench drives strobes on falling edges and samples on the next falling edge. For the same-cycle mode switch it samples one nanosecond after the writing edge. Read data and the pass-through paths are combinational, so their checks sample a short delay after the input changes, with no clock edge in between.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_LINES = 4;
    localparam int LOOP_BIT  = NUM_LINES;
    localparam int CTRL_BITS = NUM_LINES + 1;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOOP   = 1'b1
    } mode_e;
endpackage

// File: rtl/mcr_regfile.sv
module mcr_regfile #(
    parameter int DATA_W    = mcr_pkg::DATA_W,
    parameter int CTRL_BITS = mcr_pkg::CTRL_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [CTRL_BITS-1:0] wbits,
    output logic [CTRL_BITS-1:0] ctrl_q,
    output logic [DATA_W-1:0]    rdata
);
    localparam int PAD_W = DATA_W - CTRL_BITS;

    logic [CTRL_BITS-1:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        if (rd_en) begin
            rdata = {{PAD_W{1'b0}}, ctrl_q};
        end else begin
            rdata = '0;
        end
    end
endmodule

// File: rtl/mcr_router.sv
module mcr_router
    import mcr_pkg::*;
#(
    parameter int NUM_LINES = mcr_pkg::NUM_LINES
) (
    input  mode_e                mode,
    input  logic [NUM_LINES-1:0] ctrl_bits,
    input  logic [NUM_LINES-1:0] stat_ext,
    input  logic                 ser_in_ext,
    input  logic                 tx_ser,
    output logic [NUM_LINES-1:0] ctrl_pins,
    output logic [NUM_LINES-1:0] stat_eff,
    output logic                 ser_out_ext,
    output logic                 rx_ser
);
    always_comb begin
        unique case (mode)
            MODE_NORMAL: begin
                ser_out_ext = tx_ser;
                rx_ser      = ser_in_ext;
            end
            MODE_LOOP: begin
                ser_out_ext = 1'b1;
                rx_ser      = tx_ser;
            end
            default: begin
                ser_out_ext = 1'b1;
                rx_ser      = 1'b1;
            end
        endcase
    end

    // Line i: control bit i pairs with status line i in loopback.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_comb begin
            unique case (mode)
                MODE_NORMAL: begin
                    ctrl_pins[i] = ctrl_bits[i];
                    stat_eff[i]  = stat_ext[i];
                end
                MODE_LOOP: begin
                    ctrl_pins[i] = 1'b0;
                    stat_eff[i]  = ctrl_bits[i];
                end
                default: begin
                    ctrl_pins[i] = 1'b0;
                    stat_eff[i]  = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/modem_ctl_loop.sv
module modem_ctl_loop
    import mcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       ser_in_ext,
    input  logic       tx_ser,
    output logic       ser_out_ext,
    output logic       rx_ser,
    input  logic       dsr_in,
    input  logic       cts_in,
    input  logic       ri_in,
    input  logic       dcd_in,
    output logic       dtr_out,
    output logic       rts_out,
    output logic       out1_out,
    output logic       out2_out,
    output logic       dsr_eff,
    output logic       cts_eff,
    output logic       ri_eff,
    output logic       dcd_eff
);
    logic [CTRL_BITS-1:0] ctrl_q;
    logic [NUM_LINES-1:0] stat_ext;
    logic [NUM_LINES-1:0] stat_eff;
    logic [NUM_LINES-1:0] ctrl_pins;
    mode_e                mode;
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:CTRL_BITS];

    mcr_regfile #(
        .DATA_W   (DATA_W),
        .CTRL_BITS(CTRL_BITS)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wbits (wdata[CTRL_BITS-1:0]),
        .ctrl_q(ctrl_q),
        .rdata (rdata)
    );

    always_comb begin
        mode = ctrl_q[LOOP_BIT] ? MODE_LOOP : MODE_NORMAL;
    end

    assign stat_ext = {dcd_in, ri_in, cts_in, dsr_in};

    mcr_router #(
        .NUM_LINES(NUM_LINES)
    ) u_route (
        .mode       (mode),
        .ctrl_bits  (ctrl_q[NUM_LINES-1:0]),
        .stat_ext   (stat_ext),
        .ser_in_ext (ser_in_ext),
        .tx_ser     (tx_ser),
        .ctrl_pins  (ctrl_pins),
        .stat_eff   (stat_eff),
        .ser_out_ext(ser_out_ext),
        .rx_ser     (rx_ser)
    );

    assign dtr_out  = ctrl_pins[0];
    assign rts_out  = ctrl_pins[1];
    assign out1_out = ctrl_pins[2];
    assign out2_out = ctrl_pins[3];
    assign dsr_eff  = stat_eff[0];
    assign cts_eff  = stat_eff[1];
    assign ri_eff   = stat_eff[2];
    assign dcd_eff  = stat_eff[3];
endmodule

// File: rtl/mcr_checker.sv
module mcr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [4:0] ctrl_q,
    input logic       ser_in_ext,
    input logic       tx_ser,
    input logic       ser_out_ext,
    input logic       rx_ser,
    input logic [3:0] stat_in,
    input logic [3:0] pins,
    input logic [3:0] eff
);
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> ctrl_q == $past(wdata[4:0])); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(ctrl_q)); // R11
    AST_READ_MATCH: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> rdata == {3'b000, ctrl_q}); // R3
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rdata[7:5] == 3'b000); // R4
    AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_q[4] |-> (ser_out_ext == tx_ser && rx_ser == ser_in_ext && eff == stat_in && pins == ctrl_q[3:0])); // R5
    AST_LOOP_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n) ctrl_q[4] |-> ser_out_ext); // R6
    AST_LOOP_SERIAL: assert property (@(posedge clk) disable iff (!rst_n) ctrl_q[4] |-> rx_ser == tx_ser); // R7
    AST_LOOP_STATUS: assert property (@(posedge clk) disable iff (!rst_n) ctrl_q[4] |-> eff == ctrl_q[3:0]); // R8
    AST_LOOP_PINS_OFF: assert property (@(posedge clk) disable iff (!rst_n) ctrl_q[4] |-> pins == 4'b0000); // R9
endmodule

bind modem_ctl_loop mcr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .ctrl_q     (ctrl_q),
    .ser_in_ext (ser_in_ext),
    .tx_ser     (tx_ser),
    .ser_out_ext(ser_out_ext),
    .rx_ser     (rx_ser),
    .stat_in    ({dcd_in, ri_in, cts_in, dsr_in}),
    .pins       ({out2_out, out1_out, rts_out, dtr_out}),
    .eff        ({dcd_eff, ri_eff, cts_eff, dsr_eff})
);

// File: tb/tb_modem_ctl_loop.sv
`timescale 1ns/1ps
module tb_modem_ctl_loop;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ser_in_ext = 1'b1;
    logic       tx_ser = 1'b1;
    logic       ser_out_ext, rx_ser;
    logic       dsr_in = 1'b0, cts_in = 1'b0, ri_in = 1'b0, dcd_in = 1'b0;
    logic       dtr_out, rts_out, out1_out, out2_out;
    logic       dsr_eff, cts_eff, ri_eff, dcd_eff;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    modem_ctl_loop dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ser_in_ext(ser_in_ext), .tx_ser(tx_ser),
        .ser_out_ext(ser_out_ext), .rx_ser(rx_ser),
        .dsr_in(dsr_in), .cts_in(cts_in), .ri_in(ri_in), .dcd_in(dcd_in),
        .dtr_out(dtr_out), .rts_out(rts_out), .out1_out(out1_out), .out2_out(out2_out),
        .dsr_eff(dsr_eff), .cts_eff(cts_eff), .ri_eff(ri_eff), .dcd_eff(dcd_eff)
    );

    function automatic logic [3:0] pins();
        return {out2_out, out1_out, rts_out, dtr_out};
    endfunction

    function automatic logic [3:0] effs();
        return {dcd_eff, ri_eff, cts_eff, dsr_eff};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_stat(input logic [3:0] s);
        {dcd_in, ri_in, cts_in, dsr_in} = s;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = 8'h00;
    endtask

    task automatic rd(output logic [7:0] v);
        rd_en = 1'b1;
        #1;
        v = rdata;
        rd_en = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(v);
        chk("R1 read after reset", v, 8'h00);
        chk("R1 pins after reset", {4'h0, pins()}, 8'h00);
        tx_ser = 1'b0; #1;
        chk("R1 normal serial out", {7'h0, ser_out_ext}, 8'h00);
        tx_ser = 1'b1; #1;
        chk("R3 rdata idle zero", rdata, 8'h00);
    endtask

    task automatic t_write_ctrl();
        logic [7:0] v;
        wr(8'h05);
        chk("R2 pins 0101", {4'h0, pins()}, 8'h05);
        wr(8'h0A);
        chk("R2 pins 1010", {4'h0, pins()}, 8'h0A);
        rd(v);
        chk("R3 readback 0A", v, 8'h0A);
        wr(8'h0F);
        chk("R2 pins 1111", {4'h0, pins()}, 8'h0F);
    endtask

    task automatic t_upper_bits();
        logic [7:0] v;
        wr(8'hE3);
        rd(v);
        chk("R4 upper bits read zero", v, 8'h03);
        chk("R4 upper bits no pin effect", {4'h0, pins()}, 8'h03);
        chk("R4 upper bits no loop", {7'h0, ser_out_ext}, {7'h0, tx_ser});
    endtask

    task automatic t_normal_pass();
        set_stat(4'b1001); ser_in_ext = 1'b0; tx_ser = 1'b0; #1;
        chk("R5 status pass 1001", {4'h0, effs()}, 8'h09);
        chk("R5 rx follows ext", {7'h0, rx_ser}, 8'h00);
        chk("R5 tx out follows", {7'h0, ser_out_ext}, 8'h00);
        set_stat(4'b0110); ser_in_ext = 1'b1; tx_ser = 1'b1; #1;
        chk("R5 status pass 0110", {4'h0, effs()}, 8'h06);
        chk("R5 rx follows ext high", {7'h0, rx_ser}, 8'h01);
    endtask

    task automatic t_loop();
        logic [7:0] v;
        wr(8'h15);
        set_stat(4'b1010); ser_in_ext = 1'b1; tx_ser = 1'b0; #1;
        chk("R6 serial out idle", {7'h0, ser_out_ext}, 8'h01);
        chk("R7 rx from tx low", {7'h0, rx_ser}, 8'h00);
        ser_in_ext = 1'b0; tx_ser = 1'b1; #1;
        chk("R7 rx from tx high", {7'h0, rx_ser}, 8'h01);
        chk("R8 status from ctrl 0101", {4'h0, effs()}, 8'h05);
        set_stat(4'b0101); #1;
        chk("R8 ext status ignored", {4'h0, effs()}, 8'h05);
        chk("R9 pins inactive", {4'h0, pins()}, 8'h00);
        rd(v);
        chk("R9 register kept", v, 8'h15);
        wr(8'h1A);
        chk("R8 status from ctrl 1010", {4'h0, effs()}, 8'h0A);
        chk("R9 pins still inactive", {4'h0, pins()}, 8'h00);
    endtask

    task automatic t_same_cycle();
        set_stat(4'b0000); tx_ser = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wdata = 8'h00;
        @(posedge clk); #1;
        chk("R10 leave loop same edge", {7'h0, ser_out_ext}, 8'h00);
        @(negedge clk);
        wdata = 8'h13;
        @(posedge clk); #1;
        chk("R10 enter loop same edge", {7'h0, ser_out_ext}, 8'h01);
        chk("R10 status same edge", {4'h0, effs()}, 8'h03);
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic t_no_write();
        logic [7:0] v;
        @(negedge clk);
        wdata = 8'h0C;
        repeat (3) @(negedge clk);
        rd(v);
        chk("R11 no write without strobe", v, 8'h13);
        wdata = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_ctrl();
        t_upper_bits();
        t_normal_pass();
        t_loop();
        t_same_cycle();
        t_no_write();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule